// File: doc/BRIEF.md
# Indirect PCI Configuration and I/O Access Port

This block is a small register front end through which a processor reaches PCI configuration space and PCI I/O space without a direct mapping. Software first loads a 32-bit target address into an address register, then reads or writes through one of two four-byte data windows. Each data window access becomes a single downstream request. Its address is the stored target with bits [1:0] cleared, combined with the byte offset of the access inside the window.

The processor side is a pulsed request (window offset, size, direction, write data) answered by a one-cycle completion strobe with read data and an error flag. The downstream side presents one held request at a time: address, size, direction, address space and byte-lane data. It is released by a one-cycle acknowledge that carries the read data. Configuration data travels little-endian and I/O data travels big-endian. The two differ in how the processor's right-justified value is placed on the address-ordered byte lanes. Illegal size and offset combinations are refused with an error and never reach the downstream side.

Top module: `pio_port`

## Requirements
- R1: After reset, no downstream request and no completion are signalled, and a 4-byte read of the address register returns 0.
- R2: A legal write to the address register stores all 32 bits unchanged, including bits [1:0], and a later legal read returns exactly that value with rsp_err low.
- R3: The address register (window code 0) is legal only for a 4-byte access at offset 0. Any other access completes with rsp_err high and leaves the stored value unchanged.
- R4: A configuration data access (window code 1) issues dn_addr = (stored value with bits [1:0] cleared) OR offset, with dn_space = 0. Bit 31 of the stored value is never examined, so a request is issued whether it is 0 or 1.
- R5: An I/O data access (window code 2) issues dn_addr = (stored value with bits [1:0] cleared) + offset, with dn_space = 1.
- R6: The window is req_addr[3:2], the offset is req_addr[1:0], and the size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = illegal. On both data windows, offset 0 allows sizes of 1, 2 or 4 bytes, offset 2 allows 1 or 2 bytes, and offsets 1 and 3 allow 1 byte only.
- R7: An illegal access, including any access to the unmapped window code 3, produces rsp_done with rsp_err high one cycle after the request and issues no downstream request.
- R8: A legal data-window request raises dn_valid one cycle after the request. dn_valid and all dn_* fields stay steady until the cycle in which dn_ack is high. rsp_done then pulses for exactly one cycle in the following cycle, with dn_valid low.
- R9: A request pulse that arrives while a downstream request is outstanding is ignored: it changes no state and produces no completion and no further downstream request.
- R10: Downstream data lanes are in address order, with dn_wdata[7:0] and dn_rdata[7:0] holding the byte at dn_addr. For configuration accesses the value's least significant byte sits on lane 0.
- R11: For I/O accesses the value's most significant byte (for the access size) sits on lane 0, and the remaining bytes follow in descending significance.
- R12: Lanes and read-data bits beyond the access size are zero. Write completions and error completions return rsp_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request pulse from the processor |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | OFS_W | Register offset: [3:2] window, [1:0] byte offset |
| req_size | input | 2 | Size code 0/1/2 = 1/2/4 bytes |
| req_wdata | input | DATA_W | Right-justified write value |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Completion refused (illegal access) |
| rsp_rdata | output | DATA_W | Right-justified read value |
| dn_valid | output | 1 | Downstream request outstanding |
| dn_write | output | 1 | Downstream direction |
| dn_space | output | 1 | 0 = configuration, 1 = I/O |
| dn_addr | output | ADDR_W | Downstream byte address |
| dn_size | output | 2 | Downstream size code |
| dn_wdata | output | DATA_W | Downstream write lanes, address order |
| dn_ack | input | 1 | One-cycle downstream completion |
| dn_rdata | input | DATA_W | Downstream read lanes, valid with dn_ack |

## Verification
The address register is loaded with a value whose bit 31 is clear and whose low bits are non-zero, and later with one whose bit 31 is set. This separates the kept raw copy from the cleared addressing copy and shows that no enable bit gates the cycle. The same byte pattern is sent through both data windows at every size, so that a swapped or missing lane conversion shows up as a reordered value. Every size and offset pair at the table boundaries is driven, each legal one confirmed by a downstream address and each illegal one by an error with no request. A second request is injected while the downstream acknowledge is held back, to show that it leaves no trace.

// File: rtl/pio_pkg.sv
package pio_pkg;

   typedef enum logic [1:0] {
      WIN_CADDR  = 2'd0,
      WIN_CDATA  = 2'd1,
      WIN_IODATA = 2'd2,
      WIN_NONE   = 2'd3
   } win_e;

   typedef enum logic [1:0] {
      SZ_1   = 2'd0,
      SZ_2   = 2'd1,
      SZ_4   = 2'd2,
      SZ_BAD = 2'd3
   } size_e;

   localparam logic SPACE_CFG = 1'b0;
   localparam logic SPACE_IO  = 1'b1;

   function automatic logic [31:0] size_mask(input logic [1:0] sz);
      case (sz)
         SZ_1:    size_mask = 32'h0000_00FF;
         SZ_2:    size_mask = 32'h0000_FFFF;
         default: size_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic size_fits(input logic [1:0] sz, input logic [1:0] off);
      case (sz)
         SZ_1:    size_fits = 1'b1;
         SZ_2:    size_fits = (off[0] == 1'b0);
         SZ_4:    size_fits = (off == 2'd0);
         default: size_fits = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/pio_decode.sv
module pio_decode
   import pio_pkg::*;
#(
   parameter int OFS_W = 4
) (
   input  logic [OFS_W-1:0] addr,
   input  logic [1:0]       size,
   output win_e             win,
   output logic [1:0]       off,
   output logic             legal
);
   logic upper_zero;

   generate
      if (OFS_W < 4) begin : g_bad_ofs
         $error("pio_decode: OFS_W must be at least 4");
      end
      if (OFS_W > 4) begin : g_upper
         assign upper_zero = (addr[OFS_W-1:4] == '0);
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign off = addr[1:0];

   always_comb begin
      win = upper_zero ? win_e'(addr[3:2]) : WIN_NONE;
      case (win)
         WIN_CADDR:  legal = (size == SZ_4) && (off == 2'd0);
         WIN_CDATA,
         WIN_IODATA: legal = size_fits(size, off);
         default:    legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/pio_lane_conv.sv
module pio_lane_conv
   import pio_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit BIG_END = 1'b0
) (
   input  logic [DATA_W-1:0] din,
   input  logic [1:0]        size,
   output logic [DATA_W-1:0] dout
);
   localparam int NBYTES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_w
         $error("pio_lane_conv: DATA_W must be 32");
      end
      if (BIG_END) begin : g_big
         always_comb begin
            dout = '0;
            case (size)
               SZ_1: dout[7:0]  = din[7:0];
               SZ_2: dout[15:0] = {din[7:0], din[15:8]};
               default: begin
                  for (int i = 0; i < NBYTES; i++) begin
                     dout[8*i +: 8] = din[8*(NBYTES-1-i) +: 8];
                  end
               end
            endcase
         end
      end else begin : g_little
         assign dout = din & size_mask(size);
      end
   endgenerate

endmodule

// File: rtl/pio_caddr_reg.sv
module pio_caddr_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_val,
   output logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] base
);
   always_ff @(posedge clk) begin
      if (!rst_n) raw <= '0;
      else if (wr_en) raw <= wr_val;
   end

   assign base = {raw[DATA_W-1:2], 2'b00};

endmodule

// File: rtl/pio_port.sv
module pio_port
   import pio_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [OFS_W-1:0]  req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              dn_valid,
   output logic              dn_write,
   output logic              dn_space,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [1:0]        dn_size,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_ack,
   input  logic [DATA_W-1:0] dn_rdata
);
   generate
      if (ADDR_W < 2 || ADDR_W > DATA_W) begin : g_bad_aw
         $error("pio_port: ADDR_W must lie in 2..DATA_W");
      end
   endgenerate

   typedef enum logic {ST_IDLE, ST_WAIT} state_e;
   state_e state_q;

   win_e              win;
   logic [1:0]        off;
   logic              legal;
   logic              accept;
   logic              caddr_we;
   logic [DATA_W-1:0] caddr_raw, caddr_base;
   logic [DATA_W-1:0] wr_cfg, wr_io, rd_cfg, rd_io;
   logic [ADDR_W-1:0] addr_or, addr_add;

   pio_decode #(.OFS_W(OFS_W)) u_dec (
      .addr(req_addr), .size(req_size), .win(win), .off(off), .legal(legal)
   );

   assign accept   = req_valid && (state_q == ST_IDLE);
   assign caddr_we = accept && legal && (win == WIN_CADDR) && req_write;

   pio_caddr_reg #(.DATA_W(DATA_W)) u_caddr (
      .clk(clk), .rst_n(rst_n), .wr_en(caddr_we), .wr_val(req_wdata),
      .raw(caddr_raw), .base(caddr_base)
   );

   pio_lane_conv #(.DATA_W(DATA_W), .BIG_END(1'b0)) u_wr_cfg (
      .din(req_wdata), .size(req_size), .dout(wr_cfg));
   pio_lane_conv #(.DATA_W(DATA_W), .BIG_END(1'b1)) u_wr_io (
      .din(req_wdata), .size(req_size), .dout(wr_io));
   pio_lane_conv #(.DATA_W(DATA_W), .BIG_END(1'b0)) u_rd_cfg (
      .din(dn_rdata), .size(dn_size), .dout(rd_cfg));
   pio_lane_conv #(.DATA_W(DATA_W), .BIG_END(1'b1)) u_rd_io (
      .din(dn_rdata), .size(dn_size), .dout(rd_io));

   assign addr_or  = caddr_base[ADDR_W-1:0] | ADDR_W'(off);
   assign addr_add = caddr_base[ADDR_W-1:0] + ADDR_W'(off);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rsp_done  <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
         dn_valid  <= 1'b0;
         dn_write  <= 1'b0;
         dn_space  <= SPACE_CFG;
         dn_addr   <= '0;
         dn_size   <= SZ_1;
         dn_wdata  <= '0;
      end else begin
         rsp_done <= 1'b0;
         rsp_err  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (!legal) begin
                     rsp_done  <= 1'b1;
                     rsp_err   <= 1'b1;
                     rsp_rdata <= '0;
                  end else if (win == WIN_CADDR) begin
                     rsp_done  <= 1'b1;
                     rsp_rdata <= req_write ? '0 : caddr_raw;
                  end else begin
                     dn_valid <= 1'b1;
                     dn_write <= req_write;
                     dn_size  <= req_size;
                     if (win == WIN_IODATA) begin
                        dn_space <= SPACE_IO;
                        dn_addr  <= addr_add;
                        dn_wdata <= req_write ? wr_io : '0;
                     end else begin
                        dn_space <= SPACE_CFG;
                        dn_addr  <= addr_or;
                        dn_wdata <= req_write ? wr_cfg : '0;
                     end
                     state_q <= ST_WAIT;
                  end
               end
            end
            default: begin
               if (dn_ack) begin
                  dn_valid  <= 1'b0;
                  rsp_done  <= 1'b1;
                  rsp_rdata <= dn_write ? '0 : (dn_space == SPACE_IO ? rd_io : rd_cfg);
                  state_q   <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ack |=> dn_valid && $stable(dn_addr) && $stable(dn_wdata)
                             && $stable(dn_size) && $stable(dn_write));

   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && dn_ack |=> rsp_done && !dn_valid && !rsp_err);

   assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ack |=> !rsp_done);

   assert_err_nodn_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done && !dn_valid && (rsp_rdata == '0));

   assert_dn_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> (dn_size != SZ_BAD)
                   && (dn_size != SZ_4 || dn_addr[1:0] == 2'd0)
                   && (dn_size != SZ_2 || dn_addr[0] == 1'b0));

endmodule

// File: tb/tb_pio_port.sv
`timescale 1ns/1ps
module tb_pio_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_done, rsp_err;
   logic [31:0] rsp_rdata;
   logic        dn_valid, dn_write, dn_space;
   logic [31:0] dn_addr;
   logic [1:0]  dn_size;
   logic [31:0] dn_wdata;
   logic        dn_ack = 1'b0;
   logic [31:0] dn_rdata = '0;

   int n_run = 0, n_fail = 0;
   bit finished = 0;
   logic [31:0] m_caddr = 32'h0;

   always #10 clk = ~clk;

   pio_port dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .dn_valid(dn_valid), .dn_write(dn_write), .dn_space(dn_space),
      .dn_addr(dn_addr), .dn_size(dn_size), .dn_wdata(dn_wdata),
      .dn_ack(dn_ack), .dn_rdata(dn_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] lanes(input logic [31:0] v, input int nb, input bit big);
      logic [31:0] r = '0;
      for (int i = 0; i < nb; i++) begin
         if (big) r[8*i +: 8] = v[8*(nb-1-i) +: 8];
         else     r[8*i +: 8] = v[8*i +: 8];
      end
      return r;
   endfunction

   // Full behavioural expectation of one access; inj pushes a stray request while busy.
   task automatic access(input int win, input int off, input int szc, input bit wr,
                         input logic [31:0] wv, input int dly, input logic [31:0] dr,
                         input bit inj, input string tag);
      int  nb;
      bit  ok, big;
      logic [31:0] ea, er;
      nb = 1 << szc;
      ok = (szc != 3) && (win != 3) && ((off % nb) == 0)
           && (win != 0 || (szc == 2 && off == 0));
      big = (win == 2);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = 4'(win*4 + off);
      req_size = 2'(szc); req_wdata = wv;
      @(negedge clk);
      req_valid = 0;
      if (!ok) begin
         chk({tag, " R7 done"}, 32'(rsp_done), 1);
         chk({tag, " R7 err"}, 32'(rsp_err), 1);
         chk({tag, " R7 no dn"}, 32'(dn_valid), 0);
         chk({tag, " R12 rdata"}, rsp_rdata, 0);
      end else if (win == 0) begin
         chk({tag, " R2 done"}, {31'd0, rsp_done} | {30'd0, rsp_err, 1'b0}, 1);
         if (wr) begin
            m_caddr = wv;
            chk({tag, " R12 wr rdata"}, rsp_rdata, 0);
         end else chk({tag, " R2 readback"}, rsp_rdata, m_caddr);
      end else begin
         ea = big ? (m_caddr & ~32'h3) + 32'(off) : (m_caddr & ~32'h3) | 32'(off);
         chk({tag, " R8 dn_valid"}, 32'(dn_valid), 1);
         chk({tag, big ? " R5 addr" : " R4 addr"}, dn_addr, ea);
         chk({tag, " R5 space"}, 32'(dn_space), 32'(big));
         chk({tag, " R8 dir/size"}, {30'd0, dn_write, 1'b0} | 32'(dn_size) << 4,
             {30'd0, wr, 1'b0} | 32'(szc) << 4);
         if (wr) chk({tag, big ? " R11 wlanes" : " R10 wlanes"}, dn_wdata, lanes(wv, nb, big));
         for (int k = 0; k < dly; k++) begin
            if (inj && k == 0) begin
               req_valid = 1; req_write = 1; req_addr = 4'h0; req_size = 2'd2;
               req_wdata = 32'hDEAD_BEEF;
            end
            @(negedge clk);
            req_valid = 0;
            chk({tag, " R8 held"}, 32'(dn_valid), 1);
            chk({tag, " R9 no done"}, 32'(rsp_done), 0);
            chk({tag, " R8 addr stable"}, dn_addr, ea);
         end
         dn_ack = 1; dn_rdata = dr;
         @(negedge clk);
         dn_ack = 0;
         er = wr ? 32'h0 : lanes(dr, nb, big);
         chk({tag, " R8 done"}, 32'(rsp_done), 1);
         chk({tag, " R8 released"}, 32'(dn_valid), 0);
         chk({tag, " R8 no err"}, 32'(rsp_err), 0);
         chk({tag, big ? " R11 rdata" : " R10 rdata"}, rsp_rdata, er);
      end
      @(negedge clk);
      chk({tag, " R8 single pulse"}, 32'(rsp_done), 0);
      chk({tag, " R9 no extra dn"}, 32'(dn_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 dn_valid", 32'(dn_valid), 0);
      chk("R1 rsp_done", 32'(rsp_done), 0);
      access(0, 0, 2, 0, 0, 0, 0, 0, "R1 caddr reset");
      access(0, 0, 2, 1, 32'h0000_0A07, 0, 0, 0, "R2 caddr wr");
      access(0, 0, 2, 0, 0, 0, 0, 0, "R2 caddr rd");
      access(0, 0, 1, 1, 32'h0000_FFFF, 0, 0, 0, "R3 caddr sz2");
      access(0, 1, 0, 0, 0, 0, 0, 0, "R3 caddr off1");
      access(0, 0, 2, 0, 0, 0, 0, 0, "R3 caddr kept");
      access(1, 2, 1, 0, 0, 2, 32'h1122_3344, 0, "R4 cfg rd2");
      access(1, 0, 2, 1, 32'hA1B2_C3D4, 1, 0, 0, "R10 cfg wr4");
      access(1, 0, 2, 0, 0, 0, 32'hA1B2_C3D4, 0, "R10 cfg rd4");
      access(2, 0, 2, 1, 32'hA1B2_C3D4, 0, 0, 0, "R11 io wr4");
      access(2, 0, 2, 0, 0, 1, 32'hA1B2_C3D4, 0, "R11 io rd4");
      access(2, 2, 1, 0, 0, 0, 32'h0000_5566, 0, "R11 io rd2");
      access(2, 3, 0, 0, 0, 0, 32'h0000_0077, 0, "R6 io off3");
      access(2, 1, 0, 1, 32'h0000_1234, 0, 0, 0, "R12 io wr1");
      access(2, 1, 1, 0, 0, 0, 0, 0, "R6 io off1 sz2");
      access(2, 2, 2, 0, 0, 0, 0, 0, "R6 io off2 sz4");
      access(2, 3, 2, 1, 32'h1, 0, 0, 0, "R6 io off3 sz4");
      access(2, 0, 3, 0, 0, 0, 0, 0, "R6 io size3");
      access(1, 1, 1, 0, 0, 0, 0, 0, "R6 cfg off1 sz2");
      access(3, 0, 2, 0, 0, 0, 0, 0, "R7 unmapped");
      access(1, 0, 0, 0, 0, 3, 32'hFFFF_FF5A, 1, "R9 inject");
      access(0, 0, 2, 0, 0, 0, 0, 0, "R9 caddr untouched");
      access(0, 0, 2, 1, 32'h8012_3456, 0, 0, 0, "R4 caddr hi");
      access(1, 1, 0, 0, 0, 0, 32'h0000_00C3, 0, "R4 cfg bit31");
      access(2, 3, 0, 1, 32'hFFFF_FF9E, 0, 0, 0, "R5 io bit31");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule